// File: doc/BRIEF.md
# Two-Bank Sample Readout FIFO

This block stores filtered 16-bit samples in four entries and hands them to a host over a three-wire serial link (an enable line, a clock that idles high, and one data line). The entries form two banks of two. Entry 1 always holds the oldest sample written since the last completed read, and entry 4 the newest. The host drains a whole bank in one frame. It sends an 8-bit header, then keeps clocking while the block shifts out the bank's two words.

Samples arrive on a parallel port with a one-cycle valid strobe. The serial lines are asynchronous to the block clock. They are synchronised and edge-detected inside the block, so the serial clock must run several times slower than the block clock. If the store fills up, the newest sample replaces entry 4 and a sticky overflow output is raised. A completed read clears that output and restarts the write order.

Top module: `bank_fifo_reader`

## Requirements
- R1: While `ser_en_i` is high, a header bit is captured on each rising edge of `ser_clk_i`, starting with the first bit after the enable rises. The header is 8 bits in this order: a read flag (must be 1), a 3-bit chip identity sent MSB first (must be 3'b110), and a 4-bit address sent MSB first.
- R2: Address 4'b0000 selects bank 0 (entries 1 and 2). Address 4'b0010 selects bank 1 (entries 3 and 4).
- R3: From the ninth falling edge of the serial clock onward, each falling edge puts the next data bit on `ser_do_o`. The bank's first entry comes out MSB first, then its second entry MSB first, then zeros for any further clocks. A frame ended early simply delivers fewer bits.
- R4: `ser_do_oe_o` is low during the 8 header bits. It goes high at the ninth falling edge of a valid frame and returns low once `ser_en_i` falls.
- R5: Each valid sample goes into the next free entry, in order 1, 2, 3, 4, counted from reset or from the last completed read. Entries hold their values until they are overwritten.
- R6: When `ser_en_i` falls after a valid header, the read is complete. The next sample then goes to entry 1 and `ovf_o` clears.
- R7: A sample that arrives while all four entries are filled overwrites entry 4 and sets `ovf_o`. `ovf_o` stays set until a read completes.
- R8: A frame with a read flag of 0, a wrong identity, or any other address never drives the data line. It also leaves the entries, the write position and `ovf_o` unchanged.
- R9: After reset, the entries hold zero, the write position is entry 1, and `ovf_o`, `ser_do_o` and `ser_do_oe_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_data_i | input | 16 | Sample from the filter |
| smp_vld_i | input | 1 | Sample valid strobe, one cycle per sample |
| ser_en_i | input | 1 | Serial frame enable, high for the whole frame |
| ser_clk_i | input | 1 | Serial clock, idles high |
| ser_di_i | input | 1 | Serial data from the host |
| ser_do_o | output | 1 | Serial data to the host |
| ser_do_oe_o | output | 1 | Output enable for `ser_do_o` |
| ovf_o | output | 1 | Sticky overflow flag |

## Verification
Two conditions are hard to reach from the ports. The first is the overflow condition combined with rejected frames. The second is the write-position reset that only a completed read triggers. To reach them, the stimulus writes six samples, then sends frames with a wrong identity, a wrong address and a cleared read flag. It checks that the flag holds and that the next valid read returns entry 3 followed by the last overwritten sample. A short 24-clock frame and a long 56-clock frame show two things: partial drains still reset the write order, and zeros follow the two words.

// File: rtl/bfr_pkg.sv
package bfr_pkg;
    localparam int SMP_W     = 16;
    localparam int BANKS     = 2;
    localparam int PER_BANK  = 2;
    localparam int ADDR_W    = 4;
    localparam int ID_W      = 3;
    localparam logic [ID_W-1:0] CHIP_ID = 3'b110;
    localparam int ENTRIES   = BANKS * PER_BANK;
    localparam int HDR_W     = 1 + ID_W + ADDR_W;
endpackage

// File: rtl/bfr_sync.sv
module bfr_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] IDLE = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] lvl_o,
    output logic [W-1:0] rise_o,
    output logic [W-1:0] fall_o
);
    for (genvar g = 0; g < W; g++) begin : g_line
        logic [STAGES:0] pipe_d, pipe_q;

        always_comb pipe_d = {pipe_q[STAGES-1:0], async_i[g]};

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q <= {(STAGES+1){IDLE[g]}};
            else        pipe_q <= pipe_d;
        end

        assign lvl_o[g]  = pipe_q[STAGES-1];
        assign rise_o[g] = pipe_q[STAGES-1] & ~pipe_q[STAGES];
        assign fall_o[g] = ~pipe_q[STAGES-1] & pipe_q[STAGES];
    end
endmodule

// File: rtl/bfr_store.sv
module bfr_store #(
    parameter int SMP_W = bfr_pkg::SMP_W,
    parameter int ENTRIES = bfr_pkg::ENTRIES
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_i,
    input  logic [SMP_W-1:0]                wdata_i,
    input  logic                            rd_done_i,
    output logic [ENTRIES-1:0][SMP_W-1:0]   ent_o,
    output logic                            ovf_o
);
    localparam int CNT_W = $clog2(ENTRIES + 1);
    localparam int IDX_W = $clog2(ENTRIES);

    typedef struct packed {
        logic [ENTRIES-1:0][SMP_W-1:0] ent;
        logic [CNT_W-1:0]              cnt;
        logic                          ovf;
    } st_t;

    st_t st_d, st_q;
    logic [CNT_W-1:0] base;

    always_comb begin
        st_d = st_q;
        base = st_q.cnt;
        if (rd_done_i) begin
            base     = '0;
            st_d.ovf = 1'b0;
        end
        st_d.cnt = base;
        if (wr_i) begin
            if (base < CNT_W'(ENTRIES)) begin
                st_d.ent[base[IDX_W-1:0]] = wdata_i;
                st_d.cnt = base + 1'b1;
            end else begin
                st_d.ent[ENTRIES-1] = wdata_i;
                st_d.ovf = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ent_o = st_q.ent;
    assign ovf_o = st_q.ovf;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.cnt <= CNT_W'(ENTRIES)); // R5
    AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.ovf) |-> $past(wr_i && !rd_done_i && st_q.cnt == CNT_W'(ENTRIES))); // R7
    AST_READ_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done_i |=> (!st_q.ovf && st_q.cnt <= 1)); // R6
endmodule

// File: rtl/bfr_frame.sv
module bfr_frame #(
    parameter int SMP_W = bfr_pkg::SMP_W,
    parameter int BANKS = bfr_pkg::BANKS,
    parameter int PER_BANK = bfr_pkg::PER_BANK,
    parameter int ADDR_W = bfr_pkg::ADDR_W,
    parameter int ID_W = bfr_pkg::ID_W,
    parameter logic [ID_W-1:0] CHIP_ID = bfr_pkg::CHIP_ID
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 sel_i,
    input  logic                                 sel_fall_i,
    input  logic                                 sclk_rise_i,
    input  logic                                 sclk_fall_i,
    input  logic                                 sdi_i,
    input  logic [BANKS*PER_BANK-1:0][SMP_W-1:0] ent_i,
    output logic                                 sdo_o,
    output logic                                 oe_o,
    output logic                                 rd_done_o
);
    localparam int HDR_W  = 1 + ID_W + ADDR_W;
    localparam int BCW    = $clog2(HDR_W + 1);
    localparam int BANK_W = (BANKS > 1) ? $clog2(BANKS) : 1;
    localparam int SHR_W  = PER_BANK * SMP_W;

    typedef struct packed {
        logic [BCW-1:0]   bits;
        logic [HDR_W-1:0] hdr;
        logic             ok;
        logic [SHR_W-1:0] shr;
        logic             dout;
        logic             oe;
    } st_t;

    st_t st_d, st_q;
    logic [HDR_W-1:0]  hdr_nx;
    logic [ADDR_W-1:0] addr;
    logic [BANK_W-1:0] bank;
    logic              hdr_good;
    logic [SHR_W-1:0]  shr_ld;

    always_comb begin
        hdr_nx   = {st_q.hdr[HDR_W-2:0], sdi_i};
        addr     = hdr_nx[ADDR_W-1:0];
        bank     = addr[BANK_W:1];
        hdr_good = hdr_nx[HDR_W-1] && (hdr_nx[HDR_W-2 -: ID_W] == CHIP_ID)
                && !addr[0] && (addr[ADDR_W-1:BANK_W+1] == '0)
                && (int'(bank) < BANKS);
        shr_ld = '0;
        for (int k = 0; k < PER_BANK; k++)
            shr_ld[(PER_BANK-1-k)*SMP_W +: SMP_W] = ent_i[int'(bank)*PER_BANK + k];
    end

    always_comb begin
        st_d = st_q;
        if (!sel_i) begin
            st_d.bits = '0;
            st_d.hdr  = '0;
            st_d.ok   = 1'b0;
            st_d.oe   = 1'b0;
            st_d.dout = 1'b0;
        end else begin
            if (sclk_rise_i && st_q.bits < BCW'(HDR_W)) begin
                st_d.hdr  = hdr_nx;
                st_d.bits = st_q.bits + 1'b1;
                if (st_q.bits == BCW'(HDR_W - 1)) begin
                    st_d.ok  = hdr_good;
                    st_d.shr = shr_ld;
                end
            end
            if (sclk_fall_i && st_q.ok) begin
                st_d.dout = st_q.shr[SHR_W-1];
                st_d.shr  = st_q.shr << 1;
                st_d.oe   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sdo_o     = st_q.dout;
    assign oe_o      = st_q.oe;
    assign rd_done_o = sel_fall_i & st_q.ok;

    AST_OE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.oe) |-> ($past(sclk_fall_i) && st_q.bits == BCW'(HDR_W))); // R4
    AST_OE_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.oe && !sel_i) |=> !st_q.oe); // R4
    AST_QUIET_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.oe |-> !st_q.dout); // R8
endmodule

// File: rtl/bank_fifo_reader.sv
module bank_fifo_reader #(
    parameter int SMP_W = bfr_pkg::SMP_W,
    parameter int BANKS = bfr_pkg::BANKS,
    parameter int PER_BANK = bfr_pkg::PER_BANK
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SMP_W-1:0] smp_data_i,
    input  logic             smp_vld_i,
    input  logic             ser_en_i,
    input  logic             ser_clk_i,
    input  logic             ser_di_i,
    output logic             ser_do_o,
    output logic             ser_do_oe_o,
    output logic             ovf_o
);
    localparam int ENTRIES = BANKS * PER_BANK;

    logic [2:0] lvl, rise, fall;
    logic [ENTRIES-1:0][SMP_W-1:0] ent;
    logic rd_done;

    bfr_sync #(.W(3), .STAGES(2), .IDLE(3'b010)) u_sync (
        .clk(clk), .rst_n(rst_n),
        .async_i({ser_en_i, ser_clk_i, ser_di_i}),
        .lvl_o(lvl), .rise_o(rise), .fall_o(fall)
    );

    bfr_store #(.SMP_W(SMP_W), .ENTRIES(ENTRIES)) u_store (
        .clk(clk), .rst_n(rst_n),
        .wr_i(smp_vld_i), .wdata_i(smp_data_i),
        .rd_done_i(rd_done), .ent_o(ent), .ovf_o(ovf_o)
    );

    bfr_frame #(.SMP_W(SMP_W), .BANKS(BANKS), .PER_BANK(PER_BANK)) u_frame (
        .clk(clk), .rst_n(rst_n),
        .sel_i(lvl[2]), .sel_fall_i(fall[2]),
        .sclk_rise_i(rise[1]), .sclk_fall_i(fall[1]),
        .sdi_i(lvl[0]), .ent_i(ent),
        .sdo_o(ser_do_o), .oe_o(ser_do_oe_o), .rd_done_o(rd_done)
    );
endmodule

// File: tb/tb_bank_fifo_reader.sv
module tb_bank_fifo_reader;
    localparam int CLK_PER = 10;
    localparam int SCK_H = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic [15:0] smp = '0;
    logic vld = 1'b0, ser_en = 1'b0, ser_clk = 1'b1, ser_di = 1'b0;
    logic ser_do, ser_oe, ovf;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [15:0] m_ent [4];
    int m_cnt = 0;
    bit m_ovf = 0;
    logic [63:0] exp_q[$], got_q[$];
    string tag_q[$];

    always #(CLK_PER/2) clk = ~clk;

    bank_fifo_reader dut (
        .clk(clk), .rst_n(rst_n), .smp_data_i(smp), .smp_vld_i(vld),
        .ser_en_i(ser_en), .ser_clk_i(ser_clk), .ser_di_i(ser_di),
        .ser_do_o(ser_do), .ser_do_oe_o(ser_oe), .ovf_o(ovf)
    );

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1;
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    endtask

    task automatic wr(input logic [15:0] s);
        @(negedge clk); smp = s; vld = 1'b1;
        @(negedge clk); vld = 1'b0;
        if (m_cnt < 4) begin m_ent[m_cnt] = s; m_cnt++; end
        else begin m_ent[3] = s; m_ovf = 1; end
    endtask

    task automatic frame(input logic [7:0] hdr, input int nbits, output logic [63:0] got,
                         output bit oe_early, output bit oe_all, output bit oe_post);
        got = '0; oe_early = 0; oe_all = 1;
        @(negedge clk); ser_en = 1'b1;
        repeat (SCK_H) @(negedge clk);
        for (int i = 0; i < nbits; i++) begin
            ser_clk = 1'b0;
            ser_di = (i < 8) ? hdr[7-i] : 1'b0;
            repeat (SCK_H) @(negedge clk);
            if (i < 8) oe_early |= ser_oe;
            else begin
                got = {got[62:0], ser_do};
                oe_all &= ser_oe;
            end
            ser_clk = 1'b1;
            repeat (SCK_H) @(negedge clk);
        end
        ser_en = 1'b0;
        repeat (SCK_H) @(negedge clk);
        oe_post = ser_oe;
    endtask

    task automatic rd(input logic [7:0] hdr, input int nbits, input string req);
        logic [63:0] got, full;
        bit e, a, p, valid;
        int b;
        valid = hdr[7] && hdr[6:4] == 3'b110 && (hdr[3:0] == 4'h0 || hdr[3:0] == 4'h2);
        b = hdr[1] ? 1 : 0;
        if (valid) begin
            full = {m_ent[2*b], m_ent[2*b+1], 32'h0};
            exp_q.push_back(full >> (64 - (nbits - 8)));
            tag_q.push_back(req);
        end
        frame(hdr, nbits, got, e, a, p);
        if (valid) begin
            got_q.push_back(got);
            chk(e == 0, "R4 oe low in header", 64'(e), 0);
            chk(a == 1, "R4 oe high in data", 64'(a), 1);
            m_cnt = 0; m_ovf = 0;
        end else begin
            chk(e == 0 && a == 0, "R8 line undriven", 64'(a), 0);
        end
        chk(p == 0, "R4 oe released", 64'(p), 0);
        chk(ovf == m_ovf, valid ? "R6 ovf after read" : "R8 ovf unchanged", 64'(ovf), 64'(m_ovf));
    endtask

    initial begin : monitor
        forever begin
            logic [63:0] g, x;
            string t;
            wait (got_q.size() != 0);
            g = got_q.pop_front(); x = exp_q.pop_front(); t = tag_q.pop_front();
            chk(g === x, t, g, x);
        end
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin : stim
        for (int i = 0; i < 4; i++) m_ent[i] = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ser_oe == 0 && ser_do == 0, "R9 serial out idle", {ser_oe, ser_do}, 0);
        chk(ovf == 0, "R9 ovf clear", 64'(ovf), 0);
        rd(8'hE0, 40, "R9 entries zero");
        wr(16'hA1A1); wr(16'hB2B2);
        rd(8'hE0, 40, "R1 R2 R3 R5 bank0");
        wr(16'hC3C3); wr(16'hD4D4); wr(16'hE5E5); wr(16'hF6F6);
        rd(8'hE2, 40, "R2 bank1 entries 3 4");
        rd(8'hE0, 40, "R5 entries held");
        for (int i = 1; i <= 6; i++) wr(16'h1000 + 16'(i));
        @(negedge clk);
        chk(ovf == 1, "R7 ovf set", 64'(ovf), 1);
        rd(8'hB0, 40, "R8 bad id");
        rd(8'hE1, 40, "R8 bad addr");
        rd(8'h60, 40, "R8 write flag");
        rd(8'hE2, 40, "R7 entry4 overwritten");
        wr(16'h2001); wr(16'h2002);
        rd(8'hE0, 24, "R3 short frame");
        wr(16'h3001);
        rd(8'hE0, 40, "R6 pointer restart");
        rd(8'hE2, 56, "R3 trailing zeros");
        wr(16'h4001);
        rd(8'hB2, 40, "R8 bad id keeps pointer");
        wr(16'h4002);
        rd(8'hE0, 40, "R8 order kept");
        repeat (5) @(negedge clk);
        chk(exp_q.size() == 0, "R3 all frames compared", 64'(exp_q.size()), 0);
        report();
    end
endmodule